// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block decides where a 32-bit processor with fixed four-byte instructions fetches next. Each cycle it receives the address of the current instruction, a decoded control-flow kind, the offset field of that instruction and the value of the source register. It resolves conditional branches by testing that register against zero and selects one of four targets: the sequential address, a PC-relative jump target, a PC-relative branch target, or the absolute address held in the register. For the call variant it also asks for the return address to be written to a fixed link register.

All results are registered once, so they appear on the outputs at the clock edge after the inputs are sampled. The jump offset field and the shorter branch displacement field are sign-extended to the datapath width. The unit then adds them to the current PC modulo 2^XLEN. Register indices, field widths, the instruction size and the reset address are parameters.

Top module: `npc_resolve_unit`

## Requirements
- R1: While `rst_n` is low, `next_pc_o` equals RESET_PC (default 0), and `taken_o` and `link_we_o` are 0.
- R2: Every output shows the result for the inputs sampled at the previous rising clock edge (one cycle of latency).
- R3: For kind 0 (none), and for the unused codes 6 and 7, `next_pc_o` is `pc_i`+4 and `taken_o` is 0.
- R4: For kind 1 (jump), `next_pc_o` is `pc_i` plus all 26 bits of `offset_i` sign-extended to 32 bits, and `taken_o` is 1.
- R5: For kind 2 (jump-and-link), the target and `taken_o` are the same as for kind 1. In addition, `link_we_o` is 1 and `link_data_o` is `pc_i`+4.
- R6: For kind 3 (jump-register), `next_pc_o` is `rs_val_i` used as an absolute address with no PC added, and `taken_o` is 1.
- R7: For kind 4 (branch-if-zero), a zero `rs_val_i` gives `pc_i` plus the sign-extended low 16 bits of `offset_i` with `taken_o` 1. A nonzero `rs_val_i` gives `pc_i`+4 with `taken_o` 0.
- R8: For kind 5 (branch-if-not-zero), the condition is reversed: a nonzero `rs_val_i` takes the branch and zero falls through.
- R9: For branches, bits 25..16 of `offset_i` have no effect on `next_pc_o`.
- R10: `link_we_o` is 1 only for kind 2. `link_idx_o` is always 31.
- R11: All target sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc_i | input | 32 | Address of the current instruction |
| kind_i | input | 3 | Control-flow kind code (0..5, 6/7 treated as 0) |
| offset_i | input | 26 | Offset field, byte units, two's complement |
| rs_val_i | input | 32 | Value of the tested or target register |
| next_pc_o | output | 32 | Registered next fetch address |
| taken_o | output | 1 | Registered control-transfer-taken flag |
| link_we_o | output | 1 | Registered link write request |
| link_idx_o | output | 5 | Link destination register index |
| link_data_o | output | 32 | Registered return address |

## Verification
Each kind is driven with positive and negative offsets. This separates correct sign extension from zero extension and shows whether the full jump field or only the short branch field reaches the adder. Branches see zero, one and all-ones register values, with garbage in offset bits 25..16, so the zero test, its polarity and the field truncation are each isolated. A PC near the top of the address space exposes wrap handling. Kind 3 uses a register value unlike PC plus offset, which catches a relative add where an absolute load belongs. A long run of random vectors is then checked field by field against a behavioural model.

// File: rtl/npc_pkg.sv
package npc_pkg;
   typedef enum logic [2:0] {
      CF_NONE = 3'd0,
      CF_JMP  = 3'd1,
      CF_JAL  = 3'd2,
      CF_JR   = 3'd3,
      CF_BEQZ = 3'd4,
      CF_BNEZ = 3'd5
   } cf_kind_e;

   typedef enum logic [1:0] {
      SEL_SEQ  = 2'd0,
      SEL_JREL = 2'd1,
      SEL_BREL = 2'd2,
      SEL_REG  = 2'd3
   } tgt_sel_e;
endpackage

// File: rtl/npc_offset_ext.sv
module npc_offset_ext #(
   parameter int IN_W = 16,
   parameter int XLEN = 32
) (
   input  logic [IN_W-1:0] raw_i,
   output logic [XLEN-1:0] ext_o
);
   localparam int PAD_W = XLEN - IN_W;

   generate
      if (IN_W > XLEN) begin : g_bad_width
         $error("npc_offset_ext: IN_W exceeds XLEN");
      end
      if (PAD_W == 0) begin : g_pass
         assign ext_o = raw_i;
      end else begin : g_pad
         assign ext_o = {{PAD_W{raw_i[IN_W-1]}}, raw_i};
      end
   endgenerate
endmodule

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
   import npc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [2:0]      kind_i,
   input  logic [XLEN-1:0] rs_val_i,
   output tgt_sel_e        sel_o,
   output logic            taken_o,
   output logic            link_o
);
   logic rs_zero;
   assign rs_zero = (rs_val_i == '0);

   always_comb begin
      sel_o   = SEL_SEQ;
      taken_o = 1'b0;
      link_o  = 1'b0;
      case (kind_i)
         CF_JMP:  begin sel_o = SEL_JREL; taken_o = 1'b1; end
         CF_JAL:  begin sel_o = SEL_JREL; taken_o = 1'b1; link_o = 1'b1; end
         CF_JR:   begin sel_o = SEL_REG;  taken_o = 1'b1; end
         CF_BEQZ: if (rs_zero)  begin sel_o = SEL_BREL; taken_o = 1'b1; end
         CF_BNEZ: if (!rs_zero) begin sel_o = SEL_BREL; taken_o = 1'b1; end
         default: ;
      endcase
   end
endmodule

// File: rtl/npc_target_sel.sv
module npc_target_sel
   import npc_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int INSN_BYTES = 4
) (
   input  logic [XLEN-1:0] pc_i,
   input  tgt_sel_e        sel_i,
   input  logic [XLEN-1:0] joff_i,
   input  logic [XLEN-1:0] boff_i,
   input  logic [XLEN-1:0] rs_val_i,
   output logic [XLEN-1:0] next_pc_o,
   output logic [XLEN-1:0] seq_pc_o
);
   localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);
   logic [XLEN-1:0] jtgt, btgt;

   assign seq_pc_o = pc_i + STEP;
   assign jtgt     = pc_i + joff_i;
   assign btgt     = pc_i + boff_i;

   always_comb begin
      case (sel_i)
         SEL_JREL: next_pc_o = jtgt;
         SEL_BREL: next_pc_o = btgt;
         SEL_REG:  next_pc_o = rs_val_i;
         default:  next_pc_o = seq_pc_o;
      endcase
   end
endmodule

// File: rtl/npc_resolve_unit.sv
module npc_resolve_unit
   import npc_pkg::*;
#(
   parameter int              XLEN       = 32,
   parameter int              JOFF_W     = 26,
   parameter int              BOFF_W     = 16,
   parameter int              INSN_BYTES = 4,
   parameter int              IDX_W      = 5,
   parameter int              LINK_REG   = 31,
   parameter logic [XLEN-1:0] RESET_PC   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [XLEN-1:0]   pc_i,
   input  logic [2:0]        kind_i,
   input  logic [JOFF_W-1:0] offset_i,
   input  logic [XLEN-1:0]   rs_val_i,
   output logic [XLEN-1:0]   next_pc_o,
   output logic              taken_o,
   output logic              link_we_o,
   output logic [IDX_W-1:0]  link_idx_o,
   output logic [XLEN-1:0]   link_data_o
);
   localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

   generate
      if (BOFF_W > JOFF_W) begin : g_chk_boff
         $error("npc_resolve_unit: branch field wider than jump field");
      end
      if (LINK_REG >= (1 << IDX_W)) begin : g_chk_link
         $error("npc_resolve_unit: LINK_REG does not fit IDX_W");
      end
   endgenerate

   logic [XLEN-1:0] joff_ext, boff_ext, nxt_c, seq_c;
   tgt_sel_e        sel_c;
   logic            taken_c, link_c;

   npc_offset_ext #(.IN_W(JOFF_W), .XLEN(XLEN)) u_jext (
      .raw_i(offset_i), .ext_o(joff_ext));
   npc_offset_ext #(.IN_W(BOFF_W), .XLEN(XLEN)) u_bext (
      .raw_i(offset_i[BOFF_W-1:0]), .ext_o(boff_ext));

   npc_cond_eval #(.XLEN(XLEN)) u_cond (
      .kind_i(kind_i), .rs_val_i(rs_val_i),
      .sel_o(sel_c), .taken_o(taken_c), .link_o(link_c));

   npc_target_sel #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_tgt (
      .pc_i(pc_i), .sel_i(sel_c), .joff_i(joff_ext), .boff_i(boff_ext),
      .rs_val_i(rs_val_i), .next_pc_o(nxt_c), .seq_pc_o(seq_c));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         next_pc_o   <= RESET_PC;
         taken_o     <= 1'b0;
         link_we_o   <= 1'b0;
         link_data_o <= '0;
      end else begin
         next_pc_o   <= nxt_c;
         taken_o     <= taken_c;
         link_we_o   <= link_c;
         link_data_o <= seq_c;
      end
   end

   assign link_idx_o = IDX_W'(LINK_REG);

   // Fall-through always lands one instruction ahead (R3, R7, R8)
   p_fall_through_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !taken_o) |-> next_pc_o == $past(pc_i) + STEP);

   // Link request only from the call kind
   p_link_only_call_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && link_we_o) |-> $past(kind_i) == CF_JAL);

   // Return address is the sequential address
   p_link_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && link_we_o) |-> link_data_o == $past(pc_i) + STEP);

   // Register jump is absolute
   p_reg_absolute_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(kind_i) == CF_JR) |-> (taken_o && next_pc_o == $past(rs_val_i)));

   // Zero branch taken only on a zero register
   p_beqz_cond_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(kind_i) == CF_BEQZ) |-> (taken_o == ($past(rs_val_i) == '0)));

   // Not-zero branch taken only on a nonzero register
   p_bnez_cond_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(kind_i) == CF_BNEZ) |-> (taken_o == ($past(rs_val_i) != '0)));
endmodule

// File: tb/npc_resolve_unit_tb_top.sv
module npc_resolve_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pc_i = '0;
   logic [2:0]  kind_i = '0;
   logic [25:0] offset_i = '0;
   logic [31:0] rs_val_i = '0;
   logic [31:0] next_pc_o, link_data_o;
   logic        taken_o, link_we_o;
   logic [4:0]  link_idx_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   npc_resolve_unit dut_i (
      .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .kind_i(kind_i),
      .offset_i(offset_i), .rs_val_i(rs_val_i), .next_pc_o(next_pc_o),
      .taken_o(taken_o), .link_we_o(link_we_o), .link_idx_o(link_idx_o),
      .link_data_o(link_data_o));

   function automatic string tag_of(input logic [2:0] k);
      case (k)
         3'd1: return "R4";
         3'd2: return "R5";
         3'd3: return "R6";
         3'd4: return "R7";
         3'd5: return "R8";
         default: return "R3";
      endcase
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Behavioural reference: drive at negedge, result registered at next posedge (R2), compare at the negedge after
   task automatic apply(input logic [31:0] pc, input logic [2:0] k, input logic [25:0] off,
                        input logic [31:0] rs, input string extra);
      logic [31:0] jo, bo, exp_pc;
      bit          exp_tk, exp_lw;
      string       req;
      jo = 32'($signed(off));
      bo = 32'($signed(off[15:0]));
      exp_pc = pc + 32'd4; exp_tk = 0; exp_lw = 0;
      case (k)
         3'd1: begin exp_pc = pc + jo; exp_tk = 1; end
         3'd2: begin exp_pc = pc + jo; exp_tk = 1; exp_lw = 1; end
         3'd3: begin exp_pc = rs; exp_tk = 1; end
         3'd4: if (rs == 0) begin exp_pc = pc + bo; exp_tk = 1; end
         3'd5: if (rs != 0) begin exp_pc = pc + bo; exp_tk = 1; end
         default: ;
      endcase
      pc_i = pc; kind_i = k; offset_i = off; rs_val_i = rs;
      @(posedge clk);
      @(negedge clk);
      req = {tag_of(k), extra};
      chk(req, "next_pc", next_pc_o, exp_pc);
      chk(req, "taken", {31'd0, taken_o}, {31'd0, exp_tk});
      chk({req, "/R10"}, "link_we", {31'd0, link_we_o}, {31'd0, exp_lw});
      chk("R10", "link_idx", {27'd0, link_idx_o}, 32'd31);
      if (exp_lw) chk("R5", "link_data", link_data_o, pc + 32'd4);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "next_pc", next_pc_o, 32'd0);
      chk("R1", "taken", {31'd0, taken_o}, 32'd0);
      chk("R1", "link_we", {31'd0, link_we_o}, 32'd0);
      rst_n = 1'b1;
      // R2: each apply samples one cycle after its inputs
      apply(32'h0000_1000, 3'd0, 26'h3ff_ffff, 32'h5, " R2");
      apply(32'h0000_2000, 3'd6, 26'h000_0100, 32'h0, "");          // R3 unused code
      apply(32'h0000_2000, 3'd7, 26'h000_0100, 32'h0, "");
      apply(32'h0000_4000, 3'd1, 26'h000_0040, 32'h0, "");          // R4 forward
      apply(32'h0000_4000, 3'd1, 26'h3ff_ff00, 32'h0, "");          // R4 backward
      apply(32'h0000_0010, 3'd1, 26'h200_0000, 32'h0, " R11");      // wraps low
      apply(32'h0000_8000, 3'd2, 26'h000_0800, 32'h0, "");          // R5
      apply(32'h0000_8000, 3'd2, 26'h3ff_fffc, 32'hffff, "");
      apply(32'h0000_9000, 3'd3, 26'h000_0010, 32'hdead_bee0, "");  // R6
      apply(32'h0000_a000, 3'd4, 26'h3ff_0020, 32'h0, " R9");       // R7 taken, high junk
      apply(32'h0000_a000, 3'd4, 26'h000_0020, 32'h1, "");          // R7 not taken
      apply(32'h0000_a000, 3'd4, 26'h155_fff0, 32'h0, " R9");       // negative branch
      apply(32'h0000_b000, 3'd5, 26'h2aa_0040, 32'hffff_ffff, " R9"); // R8 taken
      apply(32'h0000_b000, 3'd5, 26'h000_0040, 32'h0, "");          // R8 not taken
      apply(32'hffff_fffc, 3'd0, 26'h0, 32'h0, " R11");             // wrap fall-through
      apply(32'hffff_fff0, 3'd4, 26'h000_0020, 32'h0, " R11");
      for (int i = 0; i < 400; i++)
         apply($urandom, 3'($urandom), 26'($urandom),
               ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom, "");
      // R1 again mid-run
      rst_n = 1'b0;
      #1;
      chk("R1", "next_pc", next_pc_o, 32'd0);
      chk("R1", "taken", {31'd0, taken_o}, 32'd0);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule